// File: doc/BRIEF.md
# Free-Hole Memory Allocator

This block manages the free space of a linear memory region. It holds a small table of free holes, each a base address and a length, and keeps the table sorted by base. After reset the whole region is one hole. A client sends an allocate request with a length, or a release request with a base and a length. Each request is answered by exactly one response, which carries a success flag and an address.

An allocate request picks a hole under one of three fit policies, chosen per request. The block scans the table one entry per clock. It carves the allocation from the low end of the chosen hole and keeps the remainder as a smaller hole. A release puts the region back in the table. If the released region touches a free hole on either side, or on both sides, it is joined with that hole into one larger hole. A release that needs a new table slot is refused when the table is full.

Top module: `hole_alloc`

## Requirements
- R1: After reset the table holds one hole with base 0 that spans all MEM_WORDS words. `req_ready` is high and `rsp_valid` is low, so an allocation of MEM_WORDS words succeeds at base 0 and a further allocation fails.
- R2: An allocation is served only from a hole whose length is at least the requested length. If no hole qualifies, or the requested length is zero, the response has `rsp_ok`=0 and `rsp_base`=0, and the table is left unchanged.
- R3: Policy code 0 (first fit) takes the lowest-addressed hole that qualifies. Code 3 behaves as code 0.
- R4: Policy code 1 (best fit) takes the smallest qualifying hole. Among equal lengths it takes the lowest address.
- R5: Policy code 2 (worst fit) takes the largest qualifying hole. Among equal lengths it takes the lowest address.
- R6: A successful allocation returns the chosen hole's base. The hole's base grows by the allocated length and its length shrinks by the same amount. A hole that is used up exactly leaves the table.
- R7: A release joins the region with the hole that ends at its base, with the hole that starts at its end, with both (making one hole), or with neither (inserting a new hole in address order). The response is `rsp_ok`=1 with `rsp_base` equal to the released base.
- R8: A release of length zero fails. A release that touches no hole also fails when the table already holds DEPTH holes. A failed release leaves the table unchanged and still echoes its base. A release that merges succeeds even when the table is full.
- R9: `req_op`=0 requests allocation and `req_op`=1 requests release. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low until that request's response has been given, and each request produces `rsp_valid` high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and takes a request |
| req_op | input | 1 | 0 allocate, 1 release |
| req_policy | input | 2 | Fit policy for an allocation: 0 first, 1 best, 2 worst, 3 first |
| req_base | input | AW | Base of the region being released |
| req_size | input | AW | Length requested or released |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_ok | output | 1 | Request succeeded |
| rsp_base | output | AW | Allocated base, or the released base |

## Verification
A single release can extend the hole below it and remove the hole above it in one table update. The stimulus frees regions that sit exactly between two holes, including one made while the table is full. It then judges the result through later allocations whose chosen addresses show that a single combined hole exists. Best-fit and worst-fit ties are set up by freeing two holes of equal length, so that the scan's keep-or-replace decision and the address ordering act on the same comparison. The lowest address must win.

// File: rtl/hole_alloc_pkg.sv
package hole_alloc_pkg;

    localparam logic [1:0] FIT_FIRST = 2'd0;
    localparam logic [1:0] FIT_BEST  = 2'd1;
    localparam logic [1:0] FIT_WORST = 2'd2;

    localparam logic OP_ALLOC = 1'b0;
    localparam logic OP_FREE  = 1'b1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_ALLOC = 2'd2,
        ST_FREE  = 2'd3
    } ctl_state_e;

endpackage

// File: rtl/hole_table.sv
module hole_table #(
    parameter int AW        = 12,
    parameter int DEPTH     = 8,
    parameter int MEM_WORDS = 4000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(DEPTH)-1:0]   rd_idx,
    output logic [AW-1:0]              rd_base,
    output logic [AW-1:0]              rd_size,
    output logic [$clog2(DEPTH+1)-1:0] count,
    input  logic                       apply_alloc,
    input  logic [$clog2(DEPTH)-1:0]   alloc_idx,
    input  logic [AW-1:0]              alloc_size,
    input  logic                       apply_free,
    input  logic [AW-1:0]              free_base,
    input  logic [AW-1:0]              free_size,
    output logic                       free_ok
);

    localparam int IXW = $clog2(DEPTH);
    localparam int CW  = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] base;
        logic [DEPTH-1:0][AW-1:0] size;
        logic [CW-1:0]            count;
    } tab_t;

    localparam tab_t TAB_RST = '{
        base:  '0,
        size:  {{((DEPTH - 1) * AW){1'b0}}, AW'(MEM_WORDS)},
        count: CW'(1)
    };

    tab_t tab_d, tab_q;

    logic [CW-1:0]  ins_pos;
    logic [IXW-1:0] lft_idx;
    logic [IXW-1:0] rgt_idx;
    logic           left_adj;
    logic           right_adj;

    function automatic tab_t drop_at(tab_t t, logic [IXW-1:0] r);
        tab_t o = t;
        for (int k = 0; k < DEPTH; k++) begin
            if (k >= int'(r)) begin
                if (k < DEPTH - 1) begin
                    o.base[k] = t.base[(k + 1) % DEPTH];
                    o.size[k] = t.size[(k + 1) % DEPTH];
                end else begin
                    o.base[k] = '0;
                    o.size[k] = '0;
                end
            end
        end
        o.count = t.count - 1'b1;
        return o;
    endfunction

    function automatic tab_t put_at(tab_t t, logic [CW-1:0] p,
                                    logic [AW-1:0] b, logic [AW-1:0] s);
        tab_t o = t;
        for (int k = 0; k < DEPTH; k++) begin
            if (k > int'(p)) begin
                o.base[k] = t.base[(k + DEPTH - 1) % DEPTH];
                o.size[k] = t.size[(k + DEPTH - 1) % DEPTH];
            end else if (k == int'(p)) begin
                o.base[k] = b;
                o.size[k] = s;
            end
        end
        o.count = t.count + 1'b1;
        return o;
    endfunction

    always_comb begin
        tab_d = tab_q;

        ins_pos = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if ((CW'(k) < tab_q.count) && (tab_q.base[k] < free_base)) begin
                ins_pos = CW'(k + 1);
            end
        end
        lft_idx   = (ins_pos == '0) ? '0 : IXW'(ins_pos - 1'b1);
        rgt_idx   = (ins_pos < tab_q.count) ? IXW'(ins_pos) : '0;
        left_adj  = (ins_pos != '0) &&
                    (({1'b0, tab_q.base[lft_idx]} + {1'b0, tab_q.size[lft_idx]}) == {1'b0, free_base});
        right_adj = (ins_pos < tab_q.count) &&
                    (({1'b0, free_base} + {1'b0, free_size}) == {1'b0, tab_q.base[rgt_idx]});
        free_ok   = (free_size != '0) &&
                    (left_adj || right_adj || (tab_q.count < CW'(DEPTH)));

        if (apply_free && free_ok) begin
            if (left_adj && right_adj) begin
                tab_d = drop_at(tab_q, rgt_idx);
                tab_d.size[lft_idx] = tab_q.size[lft_idx] + free_size + tab_q.size[rgt_idx];
            end else if (left_adj) begin
                tab_d.size[lft_idx] = tab_q.size[lft_idx] + free_size;
            end else if (right_adj) begin
                tab_d.base[rgt_idx] = free_base;
                tab_d.size[rgt_idx] = tab_q.size[rgt_idx] + free_size;
            end else begin
                tab_d = put_at(tab_q, ins_pos, free_base, free_size);
            end
        end else if (apply_alloc) begin
            if (tab_q.size[alloc_idx] == alloc_size) begin
                tab_d = drop_at(tab_q, alloc_idx);
            end else begin
                tab_d.base[alloc_idx] = tab_q.base[alloc_idx] + alloc_size;
                tab_d.size[alloc_idx] = tab_q.size[alloc_idx] - alloc_size;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tab_q <= TAB_RST;
        end else begin
            tab_q <= tab_d;
        end
    end

    assign rd_base = tab_q.base[rd_idx];
    assign rd_size = tab_q.size[rd_idx];
    assign count   = tab_q.count;

    // R8
    hole_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tab_q.count <= CW'(DEPTH));

    for (genvar g = 0; g < DEPTH; g++) begin : g_live
        // R6
        hole_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (CW'(g) < tab_q.count) |-> (tab_q.size[g] != '0));
    end

    for (genvar g = 0; g < DEPTH - 1; g++) begin : g_order
        // R7
        hole_gap_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (CW'(g + 1) < tab_q.count) |->
            (({1'b0, tab_q.base[g]} + {1'b0, tab_q.size[g]}) < {1'b0, tab_q.base[g + 1]}));
    end

endmodule

// File: rtl/hole_fit_scan.sv
module hole_fit_scan #(
    parameter int AW    = 12,
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     step,
    input  logic [1:0]               policy,
    input  logic [AW-1:0]            want,
    input  logic [AW-1:0]            ent_size,
    input  logic [$clog2(DEPTH)-1:0] ent_idx,
    output logic                     found,
    output logic [$clog2(DEPTH)-1:0] pick_idx
);
    import hole_alloc_pkg::*;

    localparam int IXW = $clog2(DEPTH);

    typedef struct packed {
        logic           found;
        logic [IXW-1:0] idx;
        logic [AW-1:0]  size;
    } pick_t;

    pick_t pick_d, pick_q;
    logic  fits;
    logic  take;

    always_comb begin
        pick_d = pick_q;
        fits   = (want != '0) && (ent_size >= want);
        take   = fits && (!pick_q.found ||
                          ((policy == FIT_BEST)  && (ent_size < pick_q.size)) ||
                          ((policy == FIT_WORST) && (ent_size > pick_q.size)));
        if (clear) begin
            pick_d = '0;
        end else if (step && take) begin
            pick_d.found = 1'b1;
            pick_d.idx   = ent_idx;
            pick_d.size  = ent_size;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pick_q <= '0;
        end else begin
            pick_q <= pick_d;
        end
    end

    assign found    = pick_q.found;
    assign pick_idx = pick_q.idx;

    // R3
    pick_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_q.found && !clear) |=> pick_q.found);

    // R4
    best_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_q.found && !clear && (policy == FIT_BEST)) |=> (pick_q.size <= $past(pick_q.size)));

    // R5
    worst_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_q.found && !clear && (policy == FIT_WORST)) |=> (pick_q.size >= $past(pick_q.size)));

endmodule

// File: rtl/hole_alloc.sv
module hole_alloc #(
    parameter int AW        = 12,
    parameter int DEPTH     = 8,
    parameter int MEM_WORDS = 4000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_op,
    input  logic [1:0]    req_policy,
    input  logic [AW-1:0] req_base,
    input  logic [AW-1:0] req_size,
    output logic          rsp_valid,
    output logic          rsp_ok,
    output logic [AW-1:0] rsp_base
);
    import hole_alloc_pkg::*;

    localparam int IXW = $clog2(DEPTH);
    localparam int CW  = $clog2(DEPTH + 1);

    typedef struct packed {
        ctl_state_e    st;
        logic [CW-1:0] idx;
        logic          op;
        logic [1:0]    pol;
        logic [AW-1:0] base;
        logic [AW-1:0] size;
        logic          rv;
        logic          rok;
        logic [AW-1:0] rbase;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [IXW-1:0] rd_idx;
    logic [AW-1:0]  rd_base;
    logic [AW-1:0]  rd_size;
    logic [CW-1:0]  count;
    logic           free_ok;
    logic           scan_clear;
    logic           scan_step;
    logic           found;
    logic [IXW-1:0] pick_idx;
    logic           apply_alloc;
    logic           apply_free;
    logic           first_like;

    hole_table #(.AW(AW), .DEPTH(DEPTH), .MEM_WORDS(MEM_WORDS)) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_idx      (rd_idx),
        .rd_base     (rd_base),
        .rd_size     (rd_size),
        .count       (count),
        .apply_alloc (apply_alloc),
        .alloc_idx   (pick_idx),
        .alloc_size  (ctl_q.size),
        .apply_free  (apply_free),
        .free_base   (ctl_q.base),
        .free_size   (ctl_q.size),
        .free_ok     (free_ok)
    );

    hole_fit_scan #(.AW(AW), .DEPTH(DEPTH)) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (scan_clear),
        .step     (scan_step),
        .policy   (ctl_q.pol),
        .want     (ctl_q.size),
        .ent_size (rd_size),
        .ent_idx  (rd_idx),
        .found    (found),
        .pick_idx (pick_idx)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.rv    = 1'b0;
        scan_clear  = 1'b0;
        scan_step   = 1'b0;
        apply_alloc = 1'b0;
        apply_free  = 1'b0;
        first_like  = (ctl_q.pol != FIT_BEST) && (ctl_q.pol != FIT_WORST);
        rd_idx      = (ctl_q.st == ST_SCAN) ? IXW'(ctl_q.idx) : pick_idx;

        case (ctl_q.st)
            ST_IDLE: begin
                scan_clear = 1'b1;
                if (req_valid) begin
                    ctl_d.op   = req_op;
                    ctl_d.pol  = req_policy;
                    ctl_d.base = req_base;
                    ctl_d.size = req_size;
                    ctl_d.idx  = '0;
                    ctl_d.st   = (req_op == OP_FREE) ? ST_FREE : ST_SCAN;
                end
            end
            ST_SCAN: begin
                if ((ctl_q.idx == count) || (first_like && found)) begin
                    ctl_d.st = ST_ALLOC;
                end else begin
                    scan_step = 1'b1;
                    ctl_d.idx = ctl_q.idx + 1'b1;
                end
            end
            ST_ALLOC: begin
                ctl_d.rv = 1'b1;
                ctl_d.st = ST_IDLE;
                if (found) begin
                    apply_alloc = 1'b1;
                    ctl_d.rok   = 1'b1;
                    ctl_d.rbase = rd_base;
                end else begin
                    ctl_d.rok   = 1'b0;
                    ctl_d.rbase = '0;
                end
            end
            ST_FREE: begin
                apply_free  = 1'b1;
                ctl_d.rv    = 1'b1;
                ctl_d.rok   = free_ok;
                ctl_d.rbase = ctl_q.base;
                ctl_d.st    = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready = (ctl_q.st == ST_IDLE);
    assign rsp_valid = ctl_q.rv;
    assign rsp_ok    = ctl_q.rok;
    assign rsp_base  = ctl_q.rbase;

    // R9
    rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R9
    busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2
    fail_keeps_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ok) |-> (count == $past(count)));

    // R6
    alloc_ok_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ok && (ctl_q.op == OP_ALLOC)) |->
        (({1'b0, rsp_base} + {1'b0, ctl_q.size}) <= (AW + 1)'(MEM_WORDS)));

endmodule

// File: tb/hole_alloc_tb.sv
`timescale 1ns/1ps
module hole_alloc_tb;

    localparam int AW    = 8;
    localparam int DEPTH = 4;
    localparam int MEMW  = 200;
    localparam int NVEC  = 38;

    typedef struct packed {
        logic       op;
        logic [1:0] pol;
        logic [7:0] base;
        logic [7:0] size;
        logic       ok;
        logic [7:0] eb;
        logic [3:0] rq;
    } vec_t;

    // op: 0 alloc, 1 free. pol: 0 first, 1 best, 2 worst, 3 first.
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 2'd0, 8'd0,   8'd20,  1'b1, 8'd0,   4'd6},  // R6 split
        '{1'b0, 2'd0, 8'd0,   8'd30,  1'b1, 8'd20,  4'd6},
        '{1'b0, 2'd0, 8'd0,   8'd10,  1'b1, 8'd50,  4'd6},
        '{1'b0, 2'd0, 8'd0,   8'd40,  1'b1, 8'd60,  4'd6},
        '{1'b0, 2'd0, 8'd0,   8'd15,  1'b1, 8'd100, 4'd6},
        '{1'b1, 2'd0, 8'd20,  8'd30,  1'b1, 8'd20,  4'd7},  // R7 insert
        '{1'b1, 2'd0, 8'd60,  8'd40,  1'b1, 8'd60,  4'd7},
        '{1'b0, 2'd1, 8'd0,   8'd25,  1'b1, 8'd20,  4'd4},  // R4 best
        '{1'b0, 2'd2, 8'd0,   8'd10,  1'b1, 8'd115, 4'd5},  // R5 worst
        '{1'b0, 2'd0, 8'd0,   8'd8,   1'b1, 8'd60,  4'd3},  // R3 first
        '{1'b0, 2'd0, 8'd0,   8'd100, 1'b0, 8'd0,   4'd2},  // R2 none fits
        '{1'b0, 2'd1, 8'd0,   8'd5,   1'b1, 8'd45,  4'd6},  // R6 exact fit
        '{1'b1, 2'd0, 8'd50,  8'd10,  1'b1, 8'd50,  4'd7},
        '{1'b1, 2'd0, 8'd60,  8'd8,   1'b1, 8'd60,  4'd7},  // R7 both sides
        '{1'b0, 2'd1, 8'd0,   8'd50,  1'b1, 8'd50,  4'd4},
        '{1'b1, 2'd0, 8'd100, 8'd15,  1'b1, 8'd100, 4'd7},
        '{1'b1, 2'd0, 8'd115, 8'd10,  1'b1, 8'd115, 4'd7},
        '{1'b1, 2'd0, 8'd0,   8'd20,  1'b1, 8'd0,   4'd7},
        '{1'b1, 2'd0, 8'd50,  8'd20,  1'b1, 8'd50,  4'd7},
        '{1'b0, 2'd1, 8'd0,   8'd15,  1'b1, 8'd0,   4'd4},  // R4 tie
        '{1'b0, 2'd1, 8'd0,   8'd20,  1'b1, 8'd50,  4'd4},
        '{1'b1, 2'd0, 8'd50,  8'd20,  1'b1, 8'd50,  4'd7},
        '{1'b1, 2'd0, 8'd30,  8'd5,   1'b1, 8'd30,  4'd7},
        '{1'b1, 2'd0, 8'd40,  8'd5,   1'b0, 8'd40,  4'd8},  // R8 full
        '{1'b1, 2'd0, 8'd20,  8'd10,  1'b1, 8'd20,  4'd8},  // R8 merge while full
        '{1'b1, 2'd0, 8'd35,  8'd5,   1'b1, 8'd35,  4'd7},  // R7 left only
        '{1'b1, 2'd0, 8'd45,  8'd5,   1'b1, 8'd45,  4'd7},  // R7 right only
        '{1'b1, 2'd0, 8'd40,  8'd5,   1'b1, 8'd40,  4'd7},
        '{1'b0, 2'd2, 8'd0,   8'd100, 1'b1, 8'd100, 4'd5},
        '{1'b0, 2'd0, 8'd0,   8'd56,  1'b0, 8'd0,   4'd2},
        '{1'b0, 2'd0, 8'd0,   8'd55,  1'b1, 8'd15,  4'd6},
        '{1'b0, 2'd0, 8'd0,   8'd1,   1'b0, 8'd0,   4'd2},  // R2 empty table
        '{1'b0, 2'd0, 8'd0,   8'd0,   1'b0, 8'd0,   4'd2},  // R2 zero length
        '{1'b1, 2'd0, 8'd10,  8'd0,   1'b0, 8'd10,  4'd8},  // R8 zero length
        '{1'b1, 2'd0, 8'd10,  8'd5,   1'b1, 8'd10,  4'd7},
        '{1'b1, 2'd0, 8'd30,  8'd5,   1'b1, 8'd30,  4'd7},
        '{1'b0, 2'd2, 8'd0,   8'd5,   1'b1, 8'd10,  4'd5},  // R5 tie
        '{1'b0, 2'd3, 8'd0,   8'd4,   1'b1, 8'd30,  4'd3}   // R3 code 3
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_op = 1'b0;
    logic [1:0]    req_policy = 2'd0;
    logic [AW-1:0] req_base = '0;
    logic [AW-1:0] req_size = '0;
    logic          rsp_valid;
    logic          rsp_ok;
    logic [AW-1:0] rsp_base;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    hole_alloc #(.AW(AW), .DEPTH(DEPTH), .MEM_WORDS(MEMW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_op     (req_op),
        .req_policy (req_policy),
        .req_base   (req_base),
        .req_size   (req_size),
        .rsp_valid  (rsp_valid),
        .rsp_ok     (rsp_ok),
        .rsp_base   (rsp_base)
    );

    task automatic check(input bit cond, input string rq, input string what,
                         input int act, input int exp);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_req(input logic op, input logic [1:0] pol,
                           input logic [7:0] b, input logic [7:0] s,
                           output bit busy, output bit got,
                           output logic ok, output logic [7:0] rb,
                           output bit pulse_ok);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_op = op; req_policy = pol; req_base = b; req_size = s;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        busy = !req_ready;
        got = 1'b0; ok = 1'b0; rb = '0;
        for (int w = 0; w < 40 && !got; w++) begin
            if (rsp_valid) begin
                got = 1'b1; ok = rsp_ok; rb = rsp_base;
            end else begin
                @(negedge clk);
            end
        end
        @(negedge clk);
        pulse_ok = !rsp_valid;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit busy, got, pulse_ok;
        logic ok;
        logic [7:0] rb;

        do_reset();
        // R1 reset state at the ports
        check(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
        check(rsp_valid == 1'b0, "R1", "no response after reset", int'(rsp_valid), 0);

        for (int i = 0; i < NVEC; i++) begin
            run_req(VEC[i].op, VEC[i].pol, VEC[i].base, VEC[i].size, busy, got, ok, rb, pulse_ok);
            if (i == 0) begin
                // R9 handshake and single pulse
                check(busy, "R9", "ready low while busy", int'(!busy), 0);
                check(pulse_ok, "R9", "response lasts one cycle", int'(!pulse_ok), 0);
            end
            check(got, $sformatf("R%0d", VEC[i].rq), $sformatf("vec %0d response seen", i),
                  int'(got), 1);
            check(ok == VEC[i].ok, $sformatf("R%0d", VEC[i].rq), $sformatf("vec %0d ok", i),
                  int'(ok), int'(VEC[i].ok));
            check(rb == VEC[i].eb, $sformatf("R%0d", VEC[i].rq), $sformatf("vec %0d base", i),
                  int'(rb), int'(VEC[i].eb));
        end

        // R1 full region available after a fresh reset
        do_reset();
        run_req(1'b0, 2'd0, 8'd0, 8'(MEMW), busy, got, ok, rb, pulse_ok);
        check(got && ok && rb == 8'd0, "R1", "whole region allocates at 0",
              int'(rb), 0);
        run_req(1'b0, 2'd1, 8'd0, 8'd1, busy, got, ok, rb, pulse_ok);
        check(got && !ok, "R1", "nothing left after whole allocation", int'(ok), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule